// File: doc/BRIEF.md
# Receive Queue with Foreground Buffer and Interrupt Gating

This block sits between a message receiver and a host. Each message that the receiver has already accepted (its identifier matched, its checksum was good and no error was seen) goes into a small FIFO. The oldest queued message moves into a foreground register where the host reads it. A receive-full flag shows that the foreground register holds a message the host has not yet released. While the flag is set, nothing else moves into the foreground register. The host writes a one to clear the flag when it has read the message. That clear is also what lets the next queued message move forward.

If a message arrives when every storage slot is taken, the message is dropped and a sticky overrun flag is set. The host clears this flag with its own write-one-to-clear strobe.

A four-bit interrupt enable register gates two interrupt outputs. The receive interrupt follows the full flag and the error interrupt follows the overrun flag. While the block is in initialization mode, meaning both the init request and the init acknowledge are 1, the enable bits are forced to zero. Host writes to the enable register take effect only when the init request and the init acknowledge are both 0.

Top module: `rxq_fg_ctrl`

## Requirements
- R1: After a synchronous reset, the full flag, the overrun flag, all four enable bits and both interrupt outputs are 0.
- R2: A message is accepted only when `rx_valid` and `rx_ok` are both 1. A message presented with `rx_ok` at 0 is never stored and never reaches the foreground register.
- R3: When the block is empty, a message accepted at one clock edge is in `fg_data` with `fg_full` set after the following edge.
- R4: While `fg_full` is 1 and the host does not clear it, `fg_data` and `fg_full` stay unchanged, even when messages are waiting in the FIFO.
- R5: A `clr_full` pulse while the flag is set releases the foreground register. If a message is queued, the oldest one moves in at that edge and `fg_full` stays 1. If nothing is queued, `fg_full` goes to 0. Messages leave the block in the order they arrived.
- R6: The block holds at most 5 messages: 4 in the FIFO and 1 in the foreground register. A message accepted when the FIFO is full and no message moves forward in the same cycle is dropped and sets `ovr_flag`. The stored messages are not changed. If a message moves forward in the same cycle, there is room and the new message is stored.
- R7: `ovr_flag` stays set until a `clr_ovr` pulse clears it. When a new overrun happens in the same cycle as the clear, the flag stays set.
- R8: `irq_rx` is 1 exactly when `fg_full` is 1 and enable bit 0 (receive) is 1. `irq_err` is 1 exactly when `ovr_flag` is 1 and enable bit 1 (overrun) is 1.
- R9: While `init_req` and `init_ack` are both 1, `ien` is forced to 0 at every clock edge, and writes are ignored.
- R10: An enable write (`ien_we`) loads `ien_wdata` into `ien` only when `init_req` and `init_ack` are both 0. Bit 3 is wake-up, bit 2 is status change, bit 1 is overrun and bit 0 is receive. If exactly one of `init_req` or `init_ack` is 1, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Receiver presents a message this cycle |
| rx_ok | input | 1 | Message passed the identifier, checksum and error checks |
| rx_data | input | MSG_W | Message payload |
| clr_full | input | 1 | Write-one-to-clear strobe for the full flag; releases the foreground register |
| clr_ovr | input | 1 | Write-one-to-clear strobe for the overrun flag |
| ien_we | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 4 | Enable write data: bit 3 wake-up, bit 2 status change, bit 1 overrun, bit 0 receive |
| init_req | input | 1 | Initialization request |
| init_ack | input | 1 | Initialization acknowledge |
| fg_data | output | MSG_W | Foreground message for the host to read |
| fg_full | output | 1 | Receive-full flag |
| ovr_flag | output | 1 | Overrun flag |
| ien | output | 4 | Current enable bits |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The queue is driven with several input patterns, and each one separates a different kind of fault:

- A single message into an empty block shows the two-edge latency.
- A rejected message placed between good ones would show up in the drain order if it leaked into the queue.
- A burst that arrives while the foreground register stays unreleased tests the hold rule and the point at which the queue is full.
- A new message arriving in the same cycle as a release shows whether the forward move frees a slot.
- An overrun that coincides with an overrun clear tests which one takes priority.

The enable register is then written under the four combinations of the init request and acknowledge. This tells a correct register apart from one that treats a single asserted init signal as initialization mode.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int unsigned MSG_W_DEF = 32;
    localparam int unsigned QDEPTH_DEF = 4;
    localparam int unsigned IEN_W = 4;

    // Enable register layout: wake-up, status change, overrun, receive
    typedef struct packed {
        logic wake;
        logic stat;
        logic ovr;
        logic rx;
    } ien_t;

    // Admission decision for one incoming message
    typedef struct packed {
        logic push;
        logic drop;
    } admit_t;

    function automatic admit_t admit_decide(input logic accept, input logic q_full, input logic adv);
        admit_t a;
        a.push = accept && (!q_full || adv);
        a.drop = accept && q_full && !adv;
        return a;
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int unsigned W = 32,
    parameter int unsigned D = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic                         is_empty,
    output logic                         is_full
);
    localparam int unsigned PW = (D > 1) ? $clog2(D) : 1;
    localparam int unsigned CW = $clog2(D + 1);
    localparam logic [PW-1:0] LAST = PW'(D - 1);
    localparam logic [CW-1:0] CMAX = CW'(D);

    logic [W-1:0]  mem [D];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;

    assign rdata    = mem[rptr];
    assign is_empty = (count == '0);
    assign is_full  = (count == CMAX);

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rxq_front.sv
module rxq_front #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic [W-1:0] adv_data,
    input  logic         clr_w1c,
    output logic [W-1:0] fg_data,
    output logic         full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fg_data <= '0;
            full    <= 1'b0;
        end else begin
            if (adv) begin
                fg_data <= adv_data;
                full    <= 1'b1;
            end else if (clr_w1c) begin
                full    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rxq_overrun.sv
module rxq_overrun (
    input  logic clk,
    input  logic rst,
    input  logic drop,
    input  logic clr_w1c,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (drop) begin
            flag <= 1'b1;
        end else if (clr_w1c) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_enables.sv
module rxq_enables
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_req,
    input  logic init_ack,
    input  logic we,
    input  ien_t wdata,
    output ien_t ien
);
    logic in_init, open_for_write;

    assign in_init        = init_req && init_ack;
    assign open_for_write = !init_req && !init_ack;

    always_ff @(posedge clk) begin
        if (rst || in_init) begin
            ien <= '0;
        end else if (we && open_for_write) begin
            ien <= wdata;
        end
    end
endmodule

// File: rtl/rxq_fg_ctrl.sv
module rxq_fg_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned MSG_W  = MSG_W_DEF,
    parameter int unsigned QDEPTH = QDEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_valid,
    input  logic             rx_ok,
    input  logic [MSG_W-1:0] rx_data,
    input  logic             clr_full,
    input  logic             clr_ovr,
    input  logic             ien_we,
    input  logic [IEN_W-1:0] ien_wdata,
    input  logic             init_req,
    input  logic             init_ack,
    output logic [MSG_W-1:0] fg_data,
    output logic             fg_full,
    output logic             ovr_flag,
    output logic [IEN_W-1:0] ien,
    output logic             irq_rx,
    output logic             irq_err
);
    logic             accept, adv, q_empty, q_full;
    logic [MSG_W-1:0] q_head;
    admit_t           adm;
    ien_t             ien_q;

    assign accept = rx_valid && rx_ok;
    // Head moves forward when the foreground slot is free or released now
    assign adv    = !q_empty && (!fg_full || clr_full);
    assign adm    = admit_decide(accept, q_full, adv);

    rxq_ring #(.W(MSG_W), .D(QDEPTH)) u_ring (
        .clk      (clk),
        .rst      (rst),
        .push     (adm.push),
        .wdata    (rx_data),
        .pop      (adv),
        .rdata    (q_head),
        .is_empty (q_empty),
        .is_full  (q_full)
    );

    rxq_front #(.W(MSG_W)) u_front (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .adv_data (q_head),
        .clr_w1c  (clr_full),
        .fg_data  (fg_data),
        .full     (fg_full)
    );

    rxq_overrun u_ovr (
        .clk     (clk),
        .rst     (rst),
        .drop    (adm.drop),
        .clr_w1c (clr_ovr),
        .flag    (ovr_flag)
    );

    rxq_enables u_ien (
        .clk      (clk),
        .rst      (rst),
        .init_req (init_req),
        .init_ack (init_ack),
        .we       (ien_we),
        .wdata    (ien_t'(ien_wdata)),
        .ien      (ien_q)
    );

    assign ien     = ien_q;
    assign irq_rx  = fg_full && ien_q.rx;
    assign irq_err = ovr_flag && ien_q.ovr;
endmodule

// File: rtl/rxq_fg_checker.sv
module rxq_fg_checker #(
    parameter int unsigned MSG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_full,
    input logic             clr_ovr,
    input logic             init_req,
    input logic             init_ack,
    input logic [MSG_W-1:0] fg_data,
    input logic             fg_full,
    input logic             ovr_flag,
    input logic [3:0]       ien,
    input logic             irq_rx
);
    assert_fg_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (fg_full && !clr_full) |=> (fg_full && $stable(fg_data)));

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !clr_ovr) |=> ovr_flag);

    assert_ien_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (init_req && init_ack) |=> (ien == 4'b0000));

    assert_ien_locked_R10: assert property (@(posedge clk) disable iff (rst)
        (init_req != init_ack) |=> $stable(ien));

    assert_irq_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_rx) |-> fg_full);
endmodule

bind rxq_fg_ctrl rxq_fg_checker #(.MSG_W(MSG_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr_full (clr_full),
    .clr_ovr  (clr_ovr),
    .init_req (init_req),
    .init_ack (init_ack),
    .fg_data  (fg_data),
    .fg_full  (fg_full),
    .ovr_flag (ovr_flag),
    .ien      (ien),
    .irq_rx   (irq_rx)
);

// File: tb/sim_rxq_fg_ctrl.sv
module sim_rxq_fg_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_ok, clr_full, clr_ovr, ien_we, init_req, init_ack;
    logic [31:0] rx_data;
    logic [3:0]  ien_wdata;
    logic [31:0] fg_data;
    logic        fg_full, ovr_flag, irq_rx, irq_err;
    logic [3:0]  ien;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rxq_fg_ctrl #(.MSG_W(32), .QDEPTH(4)) u0 (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ok(rx_ok), .rx_data(rx_data),
        .clr_full(clr_full), .clr_ovr(clr_ovr), .ien_we(ien_we), .ien_wdata(ien_wdata),
        .init_req(init_req), .init_ack(init_ack), .fg_data(fg_data), .fg_full(fg_full),
        .ovr_flag(ovr_flag), .ien(ien), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    typedef struct packed {
        logic        vld;
        logic        ok;
        logic        cf;
        logic        co;
        logic [31:0] din;
        logic        ef;
        logic        eo;
        logic        cfg;
        logic [31:0] efg;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00A1, 1'b0,1'b0,1'b0,32'h0,          8'd3},
        '{1'b0,1'b0,1'b0,1'b0,32'h0,         1'b1,1'b0,1'b1,32'h0000_00A1, 8'd3},
        '{1'b1,1'b0,1'b0,1'b0,32'h0000_0BAD, 1'b1,1'b0,1'b1,32'h0000_00A1, 8'd2},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00B2, 1'b1,1'b0,1'b1,32'h0000_00A1, 8'd4},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00C3, 1'b1,1'b0,1'b1,32'h0000_00A1, 8'd4},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b0,1'b1,32'h0000_00B2, 8'd5},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b0,1'b1,32'h0000_00C3, 8'd5},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b0,1'b0,1'b0,32'h0,          8'd5},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00D4, 1'b0,1'b0,1'b0,32'h0,          8'd3},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00E5, 1'b1,1'b0,1'b1,32'h0000_00D4, 8'd3},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_00F6, 1'b1,1'b0,1'b1,32'h0000_00D4, 8'd4},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_0107, 1'b1,1'b0,1'b1,32'h0000_00D4, 8'd4},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_0118, 1'b1,1'b0,1'b1,32'h0000_00D4, 8'd6},
        '{1'b1,1'b1,1'b0,1'b0,32'h0000_0DEA, 1'b1,1'b1,1'b1,32'h0000_00D4, 8'd6},
        '{1'b1,1'b1,1'b1,1'b0,32'h0000_0129, 1'b1,1'b1,1'b1,32'h0000_00E5, 8'd6},
        '{1'b0,1'b0,1'b0,1'b1,32'h0,         1'b1,1'b0,1'b1,32'h0000_00E5, 8'd7},
        '{1'b1,1'b1,1'b0,1'b1,32'h0000_0DEB, 1'b1,1'b1,1'b1,32'h0000_00E5, 8'd7},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b1,1'b1,32'h0000_00F6, 8'd6},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b1,1'b1,32'h0000_0107, 8'd6},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b1,1'b1,32'h0000_0118, 8'd6},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b1,1'b1,1'b1,32'h0000_0129, 8'd6},
        '{1'b0,1'b0,1'b1,1'b0,32'h0,         1'b0,1'b1,1'b0,32'h0,          8'd5},
        '{1'b0,1'b0,1'b0,1'b1,32'h0,         1'b0,1'b0,1'b0,32'h0,          8'd7}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rx_valid = 0; rx_ok = 0; rx_data = '0; clr_full = 0; clr_ovr = 0;
        ien_we = 0; ien_wdata = '0;
    endtask

    // Inputs set after a falling edge; one rising edge; sample at the next falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic push(input logic [31:0] d);
        rx_valid = 1; rx_ok = 1; rx_data = d;
        tick();
    endtask

    initial begin
        rst = 1; init_req = 0; init_ack = 0;
        idle_inputs();
        @(negedge clk);
        tick();
        tick();
        rst = 0;
        // R1: reset state
        chk("R1", "fg_full", {31'b0, fg_full}, 32'd0);
        chk("R1", "ovr_flag", {31'b0, ovr_flag}, 32'd0);
        chk("R1", "ien", {28'b0, ien}, 32'd0);
        chk("R1", "irqs", {30'b0, irq_rx, irq_err}, 32'd0);

        // Table walk: R2..R7
        for (int i = 0; i < NV; i++) begin
            rx_valid = TBL[i].vld; rx_ok = TBL[i].ok; rx_data = TBL[i].din;
            clr_full = TBL[i].cf; clr_ovr = TBL[i].co;
            tick();
            chk($sformatf("R%0d step %0d", TBL[i].req, i), "fg_full", {31'b0, fg_full}, {31'b0, TBL[i].ef});
            chk($sformatf("R%0d step %0d", TBL[i].req, i), "ovr_flag", {31'b0, ovr_flag}, {31'b0, TBL[i].eo});
            if (TBL[i].cfg) begin
                chk($sformatf("R%0d step %0d", TBL[i].req, i), "fg_data", fg_data, TBL[i].efg);
            end
        end

        // R10: write with init request and acknowledge both low
        ien_we = 1; ien_wdata = 4'b0011;
        tick();
        chk("R10", "ien after open write", {28'b0, ien}, 32'h3);
        chk("R8", "irq_rx idle", {31'b0, irq_rx}, 32'd0);

        // R3 / R8: one message, receive interrupt after two edges
        push(32'h0000_5151);
        chk("R3", "fg_full after one edge", {31'b0, fg_full}, 32'd0);
        tick();
        chk("R3", "fg_data", fg_data, 32'h0000_5151);
        chk("R8", "irq_rx with enable", {31'b0, irq_rx}, 32'd1);

        // R6 / R8: fill four queue slots, then one more drops
        for (int k = 0; k < 4; k++) push(32'h100 + k);
        chk("R6", "no overrun at capacity", {31'b0, ovr_flag}, 32'd0);
        push(32'h0000_0666);
        chk("R6", "overrun on fifth queued", {31'b0, ovr_flag}, 32'd1);
        chk("R8", "irq_err", {31'b0, irq_err}, 32'd1);

        // R10: only one init signal high -> write ignored
        init_req = 1; init_ack = 0; ien_we = 1; ien_wdata = 4'b1111;
        tick();
        chk("R10", "write ignored, req only", {28'b0, ien}, 32'h3);
        init_req = 0; init_ack = 1; ien_we = 1; ien_wdata = 4'b1100;
        tick();
        chk("R10", "write ignored, ack only", {28'b0, ien}, 32'h3);

        // R9: initialization mode clears enables and blocks writes
        init_req = 1; init_ack = 1; ien_we = 1; ien_wdata = 4'b1111;
        tick();
        chk("R9", "ien held zero", {28'b0, ien}, 32'd0);
        chk("R8", "irqs gated off", {30'b0, irq_rx, irq_err}, 32'd0);
        chk("R9", "flags kept", {30'b0, fg_full, ovr_flag}, 32'h3);
        init_req = 0; init_ack = 0; ien_we = 1; ien_wdata = 4'b1010;
        tick();
        chk("R10", "write after init", {28'b0, ien}, 32'hA);
        chk("R8", "irq_err on, irq_rx off", {30'b0, irq_rx, irq_err}, 32'h1);

        // R6: stored entries unchanged by the drop; drain order
        for (int k = 0; k < 4; k++) begin
            clr_full = 1;
            tick();
            chk("R6", "drain order", fg_data, 32'h100 + k);
        end
        clr_full = 1;
        tick();
        chk("R5", "empty after last release", {31'b0, fg_full}, 32'd0);

        // R1: reset mid-run
        push(32'h0000_7777);
        tick();
        rst = 1;
        tick();
        rst = 0;
        chk("R1", "flags after reset", {30'b0, fg_full, ovr_flag}, 32'd0);
        chk("R1", "ien after reset", {28'b0, ien}, 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule